// File: doc/BRIEF.md
# Folded Angle to Sine/Cosine Converter

This block turns a 10-bit pointer angle into two signed amplitude words, one for the sine coil and one for the cosine coil of a crossed-coil gauge. A full turn is split into 1024 equal steps of about 0.35 degrees. The top three code bits name one of eight 45-degree octants, and the low seven bits give a step inside that octant. Each code is placed half a step past its nominal angle, so code 0 points at about 0.18 degrees and not at exactly zero.

A single quarter-wave magnitude table with 256 entries is read through two ports, one at the step index and one at its mirror. The quadrant, taken from the octant, then chooses whether to swap the two magnitudes and whether to negate each one. The host presents a code with a one-cycle strobe. The converted pair appears on the registered outputs one clock later. An output-enable forces both words to zero and clears the valid flag while it is low. A code strobed while the enable is low is still kept, and it is shown once the enable returns.

Top module: `gauge_angle_sincos`

## Requirements
- R1: While reset is high and on the first cycle after it, both amplitude outputs are zero and the valid flag is low.
- R2: A code sampled with the load strobe high at a rising edge drives the outputs from that same edge. Its result is therefore visible one clock after the strobe.
- R3: While the load strobe stays low and the enable stays high, both outputs hold their last value.
- R4: Outputs are 12-bit two's complement. Code 0 gives cosine +2047 with sine near zero. Code 256 gives sine +2047 with cosine near zero. Code 512 gives cosine -2047 and code 768 gives sine -2047, with the other output near zero in each case.
- R5: For any code c, sine equals round(2047*sin(2*pi*(c+0.5)/1024)) within one LSB, and cosine does the same with cos. Bits 9..7 of c are the octant and bits 6..0 are the step inside it.
- R6: Adding 256 to a code gives a new sine equal to the old cosine and a new cosine equal to minus the old sine, exactly.
- R7: Neither output ever takes the value -2048.
- R8: When the enable is low at an edge, both outputs become zero and valid goes low after that edge. A code loaded while the enable is low is shown one clock after the enable returns high.
- R9: Valid goes high after an edge only if the enable was high at that edge and a code has been loaded since reset. Until a code is loaded, the outputs stay zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| angle_code | input | 10 | Angle code: octant in bits 9..7, step in bits 6..0 |
| load | input | 1 | Strobe that latches angle_code |
| out_en | input | 1 | Output enable; when low, forces zero outputs |
| sin_out | output | 12 | Signed sine amplitude, two's complement |
| cos_out | output | 12 | Signed cosine amplitude, two's complement |
| valid | output | 1 | High when the outputs carry a converted code |

## Verification
The assertions assume that load and out_en are clean, defined levels at every rising edge and that reset is applied before the first strobe. The hold property also assumes that no code changes without a strobe. The bench drives every input only on the falling clock edge and keeps it steady through the next rising edge. It sequences reset first, then loads, enable changes and idle cycles, so each strobe and each enable change is a single, defined event that the model can follow cycle by cycle.

// File: rtl/gauge_sc_pkg.sv
package gauge_sc_pkg;

    typedef enum logic [1:0] {
        QUAD_I   = 2'd0,
        QUAD_II  = 2'd1,
        QUAD_III = 2'd2,
        QUAD_IV  = 2'd3
    } quad_e;

    localparam real PI_R = 3.14159265358979323846;

    // Quarter-wave magnitude for table slot k, taken half a slot past k.
    function automatic int unsigned quarter_mag(input int k, input int depth, input int full_scale);
        real x;
        real term;
        real acc;
        x    = (real'(k) + 0.5) * PI_R / (2.0 * real'(depth));
        term = x;
        acc  = x;
        for (int n = 1; n < 12; n++) begin
            term = -term * x * x / real'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return $rtoi(acc * real'(full_scale) + 0.5);
    endfunction

endpackage

// File: rtl/gauge_sc_qrom.sv
module gauge_sc_qrom #(
    parameter int IDX_W = 8,
    parameter int MAG_W = 11
) (
    input  logic [IDX_W-1:0] idx_a,
    input  logic [IDX_W-1:0] idx_b,
    output logic [MAG_W-1:0] mag_a,
    output logic [MAG_W-1:0] mag_b
);
    import gauge_sc_pkg::*;

    localparam int DEPTH = 2 ** IDX_W;
    localparam int FULL  = 2 ** MAG_W - 1;

    logic [MAG_W-1:0] tab [DEPTH];

    for (genvar gk = 0; gk < DEPTH; gk++) begin : g_slot
        localparam int unsigned SLOT_VAL = quarter_mag(gk, DEPTH, FULL);
        assign tab[gk] = SLOT_VAL[MAG_W-1:0];
    end

    assign mag_a = tab[idx_a];
    assign mag_b = tab[idx_b];

endmodule

// File: rtl/gauge_sc_fold.sv
module gauge_sc_fold #(
    parameter int CODE_W = 10,
    parameter int AMP_W  = 12
) (
    input  logic [CODE_W-1:0]       code,
    output logic signed [AMP_W-1:0] sin_val,
    output logic signed [AMP_W-1:0] cos_val
);
    import gauge_sc_pkg::*;

    localparam int STEP_W = CODE_W - 3;
    localparam int IDX_W  = CODE_W - 2;
    localparam int MAG_W  = AMP_W - 1;

    logic [2:0]        octant;
    logic [STEP_W-1:0] step;
    quad_e             quad;
    logic [IDX_W-1:0]  fwd_idx;
    logic [IDX_W-1:0]  rev_idx;
    logic [MAG_W-1:0]  fwd_mag;
    logic [MAG_W-1:0]  rev_mag;
    logic signed [AMP_W-1:0] fwd_s;
    logic signed [AMP_W-1:0] rev_s;

    assign octant  = code[CODE_W-1 -: 3];
    assign step    = code[STEP_W-1:0];
    assign quad    = quad_e'(octant[2:1]);
    assign fwd_idx = {octant[0], step};
    assign rev_idx = ~fwd_idx;

    gauge_sc_qrom #(
        .IDX_W (IDX_W),
        .MAG_W (MAG_W)
    ) u_qrom (
        .idx_a (fwd_idx),
        .idx_b (rev_idx),
        .mag_a (fwd_mag),
        .mag_b (rev_mag)
    );

    assign fwd_s = signed'({1'b0, fwd_mag});
    assign rev_s = signed'({1'b0, rev_mag});

    always_comb begin
        unique case (quad)
            QUAD_I:   begin sin_val =  fwd_s; cos_val =  rev_s; end
            QUAD_II:  begin sin_val =  rev_s; cos_val = -fwd_s; end
            QUAD_III: begin sin_val = -fwd_s; cos_val = -rev_s; end
            default:  begin sin_val = -rev_s; cos_val =  fwd_s; end
        endcase
    end

endmodule

// File: rtl/gauge_angle_sincos.sv
module gauge_angle_sincos #(
    parameter int CODE_W = 10,
    parameter int AMP_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CODE_W-1:0]       angle_code,
    input  logic                    load,
    input  logic                    out_en,
    output logic signed [AMP_W-1:0] sin_out,
    output logic signed [AMP_W-1:0] cos_out,
    output logic                    valid
);
    logic [CODE_W-1:0]       code_q;
    logic                    loaded_q;
    logic [CODE_W-1:0]       code_sel;
    logic                    have_code;
    logic signed [AMP_W-1:0] sin_nx;
    logic signed [AMP_W-1:0] cos_nx;

    assign code_sel  = load ? angle_code : code_q;
    assign have_code = load | loaded_q;

    gauge_sc_fold #(
        .CODE_W (CODE_W),
        .AMP_W  (AMP_W)
    ) u_fold (
        .code    (code_sel),
        .sin_val (sin_nx),
        .cos_val (cos_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q   <= '0;
            loaded_q <= 1'b0;
            sin_out  <= '0;
            cos_out  <= '0;
            valid    <= 1'b0;
        end else begin
            if (load) begin
                code_q   <= angle_code;
                loaded_q <= 1'b1;
            end
            if (out_en && have_code) begin
                sin_out <= sin_nx;
                cos_out <= cos_nx;
                valid   <= 1'b1;
            end else begin
                sin_out <= '0;
                cos_out <= '0;
                valid   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/gauge_angle_sincos_chk.sv
module gauge_angle_sincos_chk #(
    parameter int AMP_W = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    load,
    input logic                    out_en,
    input logic signed [AMP_W-1:0] sin_out,
    input logic signed [AMP_W-1:0] cos_out,
    input logic                    valid
);
    localparam logic [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

    p_reset_zero_r1: assert property (@(posedge clk)
        $past(rst) |-> (sin_out == '0 && cos_out == '0 && !valid));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && $past(out_en) && $past(valid))
            |-> ($stable(sin_out) && $stable(cos_out)));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (sin_out != MOST_NEG && cos_out != MOST_NEG));

    p_disable_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(out_en)) |-> (sin_out == '0 && cos_out == '0 && !valid));

    p_valid_enable_r9: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(out_en));

endmodule

bind gauge_angle_sincos gauge_angle_sincos_chk #(
    .AMP_W (AMP_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .out_en  (out_en),
    .sin_out (sin_out),
    .cos_out (cos_out),
    .valid   (valid)
);

// File: tb/gauge_angle_sincos_tb.sv
module gauge_angle_sincos_tb;

    localparam real PI_T = 3.14159265358979323846;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [9:0]        angle_code = '0;
    logic              load = 1'b0;
    logic              out_en = 1'b0;
    logic signed [11:0] sin_out;
    logic signed [11:0] cos_out;
    logic              valid;

    int checks = 0;
    int failures = 0;

    typedef struct {
        int    s;
        int    c;
        bit    v;
        int    tol;
        string req;
    } exp_t;

    exp_t sb[$];

    logic [9:0] code_m = '0;
    bit         loaded_m = 1'b0;

    always #10 clk = ~clk;

    gauge_angle_sincos u_dut (
        .clk        (clk),
        .rst        (rst),
        .angle_code (angle_code),
        .load       (load),
        .out_en     (out_en),
        .sin_out    (sin_out),
        .cos_out    (cos_out),
        .valid      (valid)
    );

    function automatic int rnd(input real x);
        return $rtoi($floor(x + 0.5));
    endfunction

    function automatic int ideal_sin(input int c);
        return rnd(2047.0 * $sin(2.0 * PI_T * (real'(c) + 0.5) / 1024.0));
    endfunction

    function automatic int ideal_cos(input int c);
        return rnd(2047.0 * $cos(2.0 * PI_T * (real'(c) + 0.5) / 1024.0));
    endfunction

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Driver: sets inputs on the falling edge, predicts the state after the next rising edge.
    task automatic step(input bit ld, input int c, input bit en, input string req);
        exp_t e;
        angle_code = 10'(c);
        load       = ld;
        out_en     = en;
        if (ld) begin
            code_m   = 10'(c);
            loaded_m = 1'b1;
        end
        e.req = req;
        e.tol = 1;
        if (en && loaded_m) begin
            e.s = ideal_sin(int'(code_m));
            e.c = ideal_cos(int'(code_m));
            e.v = 1'b1;
        end else begin
            e.s = 0;
            e.c = 0;
            e.v = 1'b0;
        end
        sb.push_back(e);
        @(negedge clk);
        load = 1'b0;
    endtask

    // Monitor: a quarter period after each rising edge, compare against the queue head.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(absd(int'(sin_out), e.s) <= e.tol, e.req, "sin", int'(sin_out), e.s);
                check(absd(int'(cos_out), e.c) <= e.tol, e.req, "cos", int'(cos_out), e.c);
                check(valid == e.v, e.req, "valid", int'(valid), int'(e.v));
                check(sin_out != -12'sd2048 && cos_out != -12'sd2048, "R7", "min", int'(sin_out), -2047);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int s1;
        int c1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sin_out == 0 && cos_out == 0, "R1", "outputs in reset", int'(sin_out), 0);
        check(valid == 1'b0, "R1", "valid in reset", int'(valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(sin_out == 0 && cos_out == 0 && !valid, "R1", "after reset", int'(cos_out), 0);

        // R9: enabled but nothing loaded yet
        step(1'b0, 0, 1'b1, "R9");
        step(1'b0, 0, 1'b1, "R9");

        // R4: cardinal codes, exact full scale on the major axis
        step(1'b1, 0, 1'b1, "R4");
        check(cos_out == 2047 && sin_out >= 0 && sin_out <= 8, "R4", "code 0 cos", int'(cos_out), 2047);
        step(1'b1, 256, 1'b1, "R4");
        check(sin_out == 2047 && cos_out <= 0 && cos_out >= -8, "R4", "code 256 sin", int'(sin_out), 2047);
        step(1'b1, 512, 1'b1, "R4");
        check(cos_out == -2047 && sin_out <= 0 && sin_out >= -8, "R4", "code 512 cos", int'(cos_out), -2047);
        step(1'b1, 768, 1'b1, "R4");
        check(sin_out == -2047 && cos_out >= 0 && cos_out <= 8, "R4", "code 768 sin", int'(sin_out), -2047);

        // R5: sweep, including octant edges 127/128 and the last code
        for (int c = 1; c < 1024; c += 37) step(1'b1, c, 1'b1, "R5");
        step(1'b1, 127, 1'b1, "R5");
        step(1'b1, 128, 1'b1, "R5");
        step(1'b1, 895, 1'b1, "R5");
        step(1'b1, 1023, 1'b1, "R5");
        check(sin_out < 0 && sin_out >= -8 && cos_out == 2047, "R5", "code 1023 sin", int'(sin_out), -6);

        // R2 / R3: one-cycle latency, then hold without strobe
        step(1'b1, 300, 1'b1, "R2");
        check(absd(int'(sin_out), ideal_sin(300)) <= 1, "R2", "latency", int'(sin_out), ideal_sin(300));
        angle_code = 10'd700;
        step(1'b0, 700, 1'b1, "R3");
        step(1'b0, 5, 1'b1, "R3");
        check(absd(int'(sin_out), ideal_sin(300)) <= 1, "R3", "hold", int'(sin_out), ideal_sin(300));

        // R6: quarter-turn symmetry, exact
        for (int c = 3; c < 1024; c += 91) begin
            step(1'b1, c, 1'b1, "R6");
            s1 = int'(sin_out);
            c1 = int'(cos_out);
            step(1'b1, (c + 256) % 1024, 1'b1, "R6");
            check(int'(sin_out) == c1, "R6", "sin after +256", int'(sin_out), c1);
            check(int'(cos_out) == -s1, "R6", "cos after +256", int'(cos_out), -s1);
        end

        // R8: disable forces zero; a load while disabled appears after enable returns
        step(1'b1, 100, 1'b1, "R8");
        step(1'b0, 0, 1'b0, "R8");
        check(sin_out == 0 && cos_out == 0 && !valid, "R8", "disabled", int'(sin_out), 0);
        step(1'b1, 640, 1'b0, "R8");
        check(sin_out == 0 && !valid, "R8", "load while disabled", int'(sin_out), 0);
        step(1'b0, 0, 1'b1, "R8");
        check(absd(int'(sin_out), ideal_sin(640)) <= 1 && valid, "R8", "re-enable", int'(sin_out), ideal_sin(640));
        step(1'b0, 0, 1'b1, "R3");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule